// File: doc/BRIEF.md
# Vertical Blanking and Colour Reference Line Generator

This block tracks lines within each video field and produces the vertical blanking signals and the per-colour reference line strobes. It runs on a one-clock line strobe derived from the leading edge of horizontal sync, a vertical sync level and a field-parity flag. A vertical sync rise arms a restart. The next line strobe numbers that line 1 and samples the parity flag. Every later strobe advances the count. The count in force at a restart is kept as the length of the field that just ended.

Three reference lines (red, green, blue) sit at consecutive line numbers set by a programmed position. A select bit can override that position with a fixed default. The internal blanking window opens a programmed number of lines before the next field, measured against the previous field's length. It closes a programmed number of lines after the blue line. The blanking output follows the same window but always stays on for at least one line after the blue line. In even fields every line target moves one line later. A clip request adds a band of blanked lines at the top and bottom of the field. All outputs are registered and move only on a line strobe.

Top module: `vbl_refgen`

## Requirements
- R1: After reset, and until the first vertical sync has been followed by a line strobe, all five outputs are 0.
- R2: A line strobe that follows a rising edge of `vsync` numbers its line 1 and samples `field_odd` there. Every other line strobe adds one to the line number, saturating at its maximum. At the restart, the previous line number becomes the stored field length.
- R3: With `pos_sel` = 1, `ref_red`, `ref_green` and `ref_blue` are each high for exactly one line: lines P+16, P+17 and P+18 in an odd field and one line later in an even field, where P is `ref_pos`. At most one of them is high at any time.
- R4: With `pos_sel` = 0, P is taken as 4 whatever `ref_pos` holds, giving reference lines 20/21/22 (odd) or 21/22/23 (even).
- R5: `vblank` is high on every line from 1 up to and including line P+E+18 (odd) or P+E+19 (even), where E is `blank_ext` (0 to 7).
- R6: `vblank` and `vblank_out` are also high on any line L where L + `blank_lead` exceeds the stored field length, once a length has been stored.
- R7: With all programming inputs at 0, the first odd field after reset blanks exactly 22 lines on `vblank` and 23 lines on `vblank_out`.
- R8: `vblank_out` covers every line on which `vblank` is high, and its head window ends max(E,1) lines after the blue reference line, so at least one full line follows the blue line.
- R9: The outputs change only in the clock cycle right after a cycle in which `line_stb` is 1. Inputs that change between strobes take effect at the next strobe.
- R10: While `clip_en` is 1, both blanking outputs are also high on lines L ≤ `clip_lines` and on lines where L + `clip_lines` exceeds the stored field length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse at each horizontal sync leading edge |
| vsync | input | 1 | Vertical sync level; its rising edge arms a line restart |
| field_odd | input | 1 | Field parity, 1 = odd field, sampled at restart |
| blank_lead | input | 6 | Lines of blanking before the next field |
| ref_pos | input | 4 | Programmed reference line position P |
| blank_ext | input | 3 | Lines of blanking after the blue reference line E |
| pos_sel | input | 1 | 1 = use `ref_pos`, 0 = fixed position 4 |
| clip_en | input | 1 | Vertical clip request |
| clip_lines | input | 6 | Number of clipped lines at top and at bottom |
| vblank | output | 1 | Internal vertical blanking |
| vblank_out | output | 1 | Blanking output with guaranteed post-blue gap |
| ref_red | output | 1 | Red reference line strobe |
| ref_green | output | 1 | Green reference line strobe |
| ref_blue | output | 1 | Blue reference line strobe |

## Verification
Every output is a register loaded at the clock edge that samples `line_stb`. So a result is due exactly one edge after the strobe that opens its line, and it holds until the edge after the next strobe. The bench drives inputs on falling edges. It updates a behavioural line model when it raises the strobe and compares all five outputs against the model 1 ns after every rising edge. Config changes are made between strobes to show that they wait for the next line. Directed checks also read the line index of the red strobe in each field and the number of blanked lines in the first field.

// File: rtl/vbl_pkg.sv
package vbl_pkg;

    typedef struct packed {
        logic vblank;
        logic vblank_out;
        logic ref_red;
        logic ref_green;
        logic ref_blue;
    } vbl_out_t;

    localparam int unsigned DEFAULT_POS = 4;
    localparam int unsigned RED_OFS     = 16;

endpackage

// File: rtl/vbl_line_tracker.sv
module vbl_line_tracker #(
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              vsync,
    input  logic              field_odd,
    output logic [LINE_W-1:0] cnt_nxt,
    output logic [LINE_W-1:0] len_nxt,
    output logic              len_ok_nxt,
    output logic              synced_nxt,
    output logic              odd_nxt
);

    localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

    typedef struct packed {
        logic [LINE_W-1:0] cnt;
        logic [LINE_W-1:0] len;
        logic              len_ok;
        logic              synced;
        logic              odd;
        logic              pend;
        logic              vs;
    } trk_t;

    trk_t trk_d, trk_q;
    logic vs_rise;
    logic restart;

    always_comb begin
        trk_d   = trk_q;
        vs_rise = vsync && !trk_q.vs;
        restart = line_stb && (trk_q.pend || vs_rise);
        trk_d.vs = vsync;
        if (vs_rise) begin
            trk_d.pend = 1'b1;
        end
        if (restart) begin
            trk_d.pend   = 1'b0;
            trk_d.cnt    = {{(LINE_W-1){1'b0}}, 1'b1};
            trk_d.odd    = field_odd;
            trk_d.synced = 1'b1;
            if (trk_q.synced) begin
                trk_d.len    = trk_q.cnt;
                trk_d.len_ok = 1'b1;
            end
        end else if (line_stb && trk_q.synced && trk_q.cnt != CNT_MAX) begin
            trk_d.cnt = trk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign cnt_nxt    = trk_d.cnt;
    assign len_nxt    = trk_d.len;
    assign len_ok_nxt = trk_d.len_ok;
    assign synced_nxt = trk_d.synced;
    assign odd_nxt    = trk_d.odd;

    AST_RESTART_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && vsync && !trk_q.vs) |=> (trk_q.cnt == 1)); // R2
    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.synced |-> (trk_q.cnt != 0)); // R2

endmodule

// File: rtl/vbl_window_calc.sv
module vbl_window_calc
    import vbl_pkg::*;
#(
    parameter int unsigned LINE_W = 11,
    parameter int unsigned LEAD_W = 6,
    parameter int unsigned POS_W  = 4,
    parameter int unsigned EXT_W  = 3,
    parameter int unsigned CLIP_W = 6
) (
    input  logic [LINE_W-1:0] cnt,
    input  logic [LINE_W-1:0] len,
    input  logic              len_ok,
    input  logic              synced,
    input  logic              odd,
    input  logic [LEAD_W-1:0] blank_lead,
    input  logic [POS_W-1:0]  ref_pos,
    input  logic [EXT_W-1:0]  blank_ext,
    input  logic              pos_sel,
    input  logic              clip_en,
    input  logic [CLIP_W-1:0] clip_lines,
    output vbl_out_t          win
);

    localparam int unsigned WW = LINE_W + 2;

    logic [WW-1:0] cnt_w, len_w, pos_w, red_l, blue_l, end_l, out_end_l;
    logic [WW-1:0] ext_w, gap_w, lead_sum, clip_sum, clip_w;
    logic          tail_hit, clip_hit;

    always_comb begin
        cnt_w    = WW'(cnt);
        len_w    = WW'(len);
        ext_w    = WW'(blank_ext);
        clip_w   = WW'(clip_lines);
        pos_w    = pos_sel ? WW'(ref_pos) : WW'(DEFAULT_POS);
        red_l    = pos_w + WW'(RED_OFS) + (odd ? WW'(0) : WW'(1));
        blue_l   = red_l + WW'(2);
        end_l    = blue_l + ext_w;
        gap_w    = (blank_ext == '0) ? WW'(1) : ext_w;
        out_end_l = blue_l + gap_w;
        lead_sum = cnt_w + WW'(blank_lead);
        clip_sum = cnt_w + clip_w;
        tail_hit = len_ok && (lead_sum > len_w);
        clip_hit = clip_en && ((cnt_w <= clip_w) || (len_ok && clip_sum > len_w));

        win = '0;
        if (synced) begin
            win.ref_red    = (cnt_w == red_l);
            win.ref_green  = (cnt_w == red_l + WW'(1));
            win.ref_blue   = (cnt_w == blue_l);
            win.vblank     = (cnt_w <= end_l) || tail_hit || clip_hit;
            win.vblank_out = (cnt_w <= out_end_l) || tail_hit || clip_hit;
        end
    end

endmodule

// File: rtl/vbl_refgen.sv
module vbl_refgen
    import vbl_pkg::*;
#(
    parameter int unsigned LINE_W = 11,
    parameter int unsigned LEAD_W = 6,
    parameter int unsigned POS_W  = 4,
    parameter int unsigned EXT_W  = 3,
    parameter int unsigned CLIP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              vsync,
    input  logic              field_odd,
    input  logic [LEAD_W-1:0] blank_lead,
    input  logic [POS_W-1:0]  ref_pos,
    input  logic [EXT_W-1:0]  blank_ext,
    input  logic              pos_sel,
    input  logic              clip_en,
    input  logic [CLIP_W-1:0] clip_lines,
    output logic              vblank,
    output logic              vblank_out,
    output logic              ref_red,
    output logic              ref_green,
    output logic              ref_blue
);

    logic [LINE_W-1:0] cnt_nxt, len_nxt;
    logic              len_ok_nxt, synced_nxt, odd_nxt;
    vbl_out_t          win;
    vbl_out_t          out_d, out_q;

    vbl_line_tracker #(.LINE_W(LINE_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_stb   (line_stb),
        .vsync      (vsync),
        .field_odd  (field_odd),
        .cnt_nxt    (cnt_nxt),
        .len_nxt    (len_nxt),
        .len_ok_nxt (len_ok_nxt),
        .synced_nxt (synced_nxt),
        .odd_nxt    (odd_nxt)
    );

    vbl_window_calc #(
        .LINE_W (LINE_W),
        .LEAD_W (LEAD_W),
        .POS_W  (POS_W),
        .EXT_W  (EXT_W),
        .CLIP_W (CLIP_W)
    ) u_win (
        .cnt        (cnt_nxt),
        .len        (len_nxt),
        .len_ok     (len_ok_nxt),
        .synced     (synced_nxt),
        .odd        (odd_nxt),
        .blank_lead (blank_lead),
        .ref_pos    (ref_pos),
        .blank_ext  (blank_ext),
        .pos_sel    (pos_sel),
        .clip_en    (clip_en),
        .clip_lines (clip_lines),
        .win        (win)
    );

    always_comb begin
        out_d = out_q;
        if (line_stb) begin
            out_d = win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign vblank     = out_q.vblank;
    assign vblank_out = out_q.vblank_out;
    assign ref_red    = out_q.ref_red;
    assign ref_green  = out_q.ref_green;
    assign ref_blue   = out_q.ref_blue;

    AST_REF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_red, ref_green, ref_blue})); // R3
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_stb) |-> $stable(out_q)); // R9
    AST_OUT_COVERS_INT: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |-> vblank_out); // R8
    AST_BLUE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && ref_blue) |=> vblank_out); // R8

endmodule

// File: tb/vbl_refgen_test.sv
`timescale 1ns/1ps
module vbl_refgen_test;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       line_stb = 0, vsync = 0, field_odd = 1;
    logic [5:0] blank_lead = 0;
    logic [3:0] ref_pos = 0;
    logic [2:0] blank_ext = 0;
    logic       pos_sel = 0, clip_en = 0;
    logic [5:0] clip_lines = 0;
    logic       vblank, vblank_out, ref_red, ref_green, ref_blue;

    int n_cmp = 0, n_bad = 0;

    // behavioural model state
    int  m_cnt = 0, m_len = 0;
    bit  m_lenv = 0, m_sync = 0, m_odd = 0, m_pend = 0;
    bit  e_vb = 0, e_vo = 0, e_r = 0, e_g = 0, e_b = 0;

    // per-field observation
    int  li = 0, red_at = 0, nblk = 0, nout = 0;

    always #2.5 clk = ~clk;

    vbl_refgen uut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync(vsync),
        .field_odd(field_odd), .blank_lead(blank_lead), .ref_pos(ref_pos),
        .blank_ext(blank_ext), .pos_sel(pos_sel), .clip_en(clip_en),
        .clip_lines(clip_lines), .vblank(vblank), .vblank_out(vblank_out),
        .ref_red(ref_red), .ref_green(ref_green), .ref_blue(ref_blue)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int ea, rp, red, blue, endl, oend;
        bit tail, clp;
        if (m_pend) begin
            if (m_sync) begin m_len = m_cnt; m_lenv = 1; end
            m_cnt = 1; m_sync = 1; m_odd = field_odd; m_pend = 0;
        end else if (m_sync && m_cnt < 2047) begin
            m_cnt++;
        end
        if (!m_sync) begin
            {e_vb, e_vo, e_r, e_g, e_b} = '0;
            return;
        end
        ea   = m_odd ? 0 : 1;
        rp   = pos_sel ? int'(ref_pos) : 4;
        red  = rp + 16 + ea;
        blue = red + 2;
        endl = blue + int'(blank_ext);
        oend = blue + ((blank_ext == 0) ? 1 : int'(blank_ext));
        tail = m_lenv && (m_cnt + int'(blank_lead) > m_len);
        clp  = clip_en && (m_cnt <= int'(clip_lines) ||
                           (m_lenv && m_cnt + int'(clip_lines) > m_len));
        e_r  = (m_cnt == red);
        e_g  = (m_cnt == red + 1);
        e_b  = (m_cnt == blue);
        e_vb = (m_cnt <= endl) || tail || clp;
        e_vo = (m_cnt <= oend) || tail || clp;
    endtask

    // compare every clock, 1 ns after the rising edge
    always @(posedge clk) begin
        #1;
        check(vblank == e_vb, "R5 R6 R9 R10 vblank", vblank, e_vb);
        check(vblank_out == e_vo, "R8 R9 R10 vblank_out", vblank_out, e_vo);
        check({ref_red, ref_green, ref_blue} == {e_r, e_g, e_b},
              "R3 R4 R9 ref rgb", {ref_red, ref_green, ref_blue}, {e_r, e_g, e_b});
    end

    task automatic do_line();
        @(negedge clk);
        line_stb = 1;
        model_step();
        @(posedge clk); #1.2;
        li++;
        if (ref_red) red_at = li;
        if (vblank) nblk++;
        if (vblank_out) nout++;
        @(negedge clk);
        line_stb = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_field(input int n, input bit odd);
        @(negedge clk);
        vsync = 1; field_odd = odd; m_pend = 1;
        @(negedge clk);
        vsync = 0;
        li = 0; red_at = 0; nblk = 0; nout = 0;
        for (int i = 0; i < n; i++) do_line();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check({vblank, vblank_out, ref_red, ref_green, ref_blue} == 0,
              "R1 outputs in reset", {vblank, vblank_out, ref_red, ref_green, ref_blue}, 0);
        rst_n = 1;
        for (int i = 0; i < 3; i++) do_line();
        check(nblk == 0 && nout == 0, "R1 no blanking before sync", nblk + nout, 0);

        // R7, R4, R2: defaults, odd field
        do_field(262, 1);
        check(nblk == 22, "R7 vblank lines", nblk, 22);
        check(nout == 23, "R7 R8 vblank_out lines", nout, 23);
        check(red_at == 20, "R2 R4 odd red line", red_at, 20);

        // even field, defaults
        do_field(263, 0);
        check(red_at == 21, "R2 R4 even red line", red_at, 21);

        // R3: programmed position, odd
        pos_sel = 1; ref_pos = 7; blank_ext = 3; blank_lead = 5;
        do_field(262, 1);
        check(red_at == 23, "R3 odd red line", red_at, 23);

        // R3 even
        do_field(263, 0);
        check(red_at == 24, "R3 even red line", red_at, 24);

        // R4: select off ignores ref_pos
        pos_sel = 0; ref_pos = 9; blank_ext = 0; blank_lead = 2;
        do_field(262, 1);
        check(red_at == 20, "R4 ref_pos ignored", red_at, 20);

        // R10: clip band, R8 gap with ext 0
        pos_sel = 1; ref_pos = 2; clip_en = 1; clip_lines = 30; blank_lead = 0;
        do_field(262, 1);
        check(red_at == 18, "R3 clip field red line", red_at, 18);
        check(nblk == 60, "R10 clip blanked lines", nblk, 60);

        // R9: config changes between strobes
        clip_en = 0; blank_ext = 7;
        do_field(40, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); ref_pos = 4'(i); blank_ext = 3'(i); blank_lead = 6'(i);
            do_line();
        end
        do_field(262, 1);
        check(red_at == 16 + int'(ref_pos), "R3 R9 final red line", red_at, 16 + int'(ref_pos));

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule